// File: doc/BRIEF.md
# Fixed-Coefficient Fixed-Point FIR Filter

This block is a direct-form finite impulse response filter whose taps are fixed when the design is elaborated. Signed fixed-point samples enter in an I/O format and are first widened to the coefficient format. The left side gets sign bits and the right side gets zero fraction bits. The widened sample then enters a delay line that advances only on an enable. Every tap is multiplied by its own integer coefficient. The products are summed in a ripple chain without registers, so the result appears directly after the edge that moved the delay line.

The sum carries twice the coefficient fraction bits. Two arithmetic right shifts return it to the I/O format: first by the coefficient fraction count, then by the difference in fraction counts. Each shift truncates to its target width. A parameter selects the port style. In the plain style a sample enable moves the line. In the stream style the slave valid moves the line, the slave ready is always high, and the master valid is the slave valid delayed by one register. The master ready has no effect.

A second parameter picks the reset polarity, and reset is synchronous. A format with more I/O integer bits than coefficient integer bits is rejected at elaboration, and so is one with more I/O fraction bits than coefficient fraction bits.

Top module: `fxp_fir`

## Requirements
- R1: A reset seen at a clock edge clears all ORDER+1 taps, so the output reads zero right after that edge even if the enable or valid is high in the same cycle.
- R2: At an edge with the enable low and reset inactive, every tap keeps its value, so the output does not change whatever the input does.
- R3: At an edge with the enable high, tap 0 takes the widened input and tap k takes tap k-1. The output shows the new taps right after that edge, with no added latency.
- R4: The input is widened by sign-extending it with (CF_W-CF_FRAC)-(IO_W-IO_FRAC) bits and then appending CF_FRAC-IO_FRAC zero bits. With IO_W=12, IO_FRAC=10, CF_W=20, CF_FRAC=16 and coefficient 0 equal to 5000, an input of -2048 entered once gives an output of -157.
- R5: The sum is the total over k of tap k times coefficient k, modulo 2^(2*CF_W). Coefficient k sits at bits [k*CF_W +: CF_W] of COEF_VEC. In the default format an input of -32768 entered once, followed by zeros, gives -coefficient k after k+1 enables, and zero after ORDER+2.
- R6: The output equals (sum >>> CF_FRAC), truncated to CF_W bits, then shifted >>> (CF_FRAC-IO_FRAC) and truncated to IO_W bits. Rounding is toward minus infinity and overflow wraps in two's complement.
- R7: In the stream style, m_axis_tvalid is a register that loads s_axis_tvalid every cycle and reads 0 right after a reset edge.
- R8: In the stream style the delay line advances on s_axis_tvalid and smp_en is ignored. s_axis_tready stays 1, and m_axis_tready has no effect on any output.
- R9: In the plain style the delay line advances on smp_en and s_axis_tvalid is ignored. m_axis_tvalid and s_axis_tready stay 0.
- R10: With RST_ACT_LOW=1, reset acts when rst is 0. With RST_ACT_LOW=0, reset acts when rst is 1. A level of rst that is not active leaves the taps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, polarity set by RST_ACT_LOW |
| smp_en | input | 1 | Sample enable (plain style) |
| smp_in | input | IO_W | Signed input sample, IO_FRAC fraction bits |
| s_axis_tvalid | input | 1 | Input valid, advances the line (stream style) |
| s_axis_tready | output | 1 | Input ready: 1 in stream style, 0 in plain style |
| smp_out | output | IO_W | Signed filtered sample, IO_FRAC fraction bits |
| m_axis_tvalid | output | 1 | Output valid, delayed copy of input valid (stream style) |
| m_axis_tready | input | 1 | Output ready, not used |

## Verification
Two events can meet at one edge: a reset and a shift request, whether an enable or a valid. The bench holds smp_en and s_axis_tvalid high with fresh non-zero data through every reset, both at start-up and in mid-run resets that hit one instance while the other keeps shifting. Reset must win in every case. The taps and m_axis_tvalid must read zero right after the edge, and the behavioural queue model, which clears before it shifts, must agree on every following clock.

// File: rtl/fxp_fir_pkg.sv
package fxp_fir_pkg;

  typedef enum bit {
    PORT_PLAIN  = 1'b0,
    PORT_STREAM = 1'b1
  } port_style_e;

  // integer bits of a signed fixed-point word (sign included)
  function automatic int int_bits(input int width, input int frac);
    return width - frac;
  endfunction

  // map the raw reset pin to an active-high internal clear
  function automatic logic reset_hit(input logic raw, input bit active_low);
    return active_low ? ~raw : raw;
  endfunction

endpackage

// File: rtl/fxp_fir_align.sv
module fxp_fir_align
  import fxp_fir_pkg::*;
#(
  parameter int IO_W    = 16,
  parameter int IO_FRAC = 15,
  parameter int CF_W    = 16,
  parameter int CF_FRAC = 15
) (
  input  logic signed [IO_W-1:0] raw,
  output logic signed [CF_W-1:0] aligned
);

  localparam int EXT = int_bits(CF_W, CF_FRAC) - int_bits(IO_W, IO_FRAC);
  localparam int PAD = CF_FRAC - IO_FRAC;

  generate
    if (EXT < 0 || PAD < 0) begin : g_bad_fmt
      $error("fxp_fir_align: I/O format does not fit in the coefficient format");
    end
  endgenerate

  // sign-extend to the coefficient width, then move the binary point
  function automatic logic signed [CF_W-1:0] widen(input logic signed [IO_W-1:0] v);
    logic signed [CF_W-1:0] w;
    w = CF_W'(v);
    return w <<< PAD;
  endfunction

  assign aligned = widen(raw);

endmodule

// File: rtl/fxp_fir_taps.sv
module fxp_fir_taps #(
  parameter int TAPS = 9,
  parameter int W    = 16
) (
  input  logic                clk,
  input  logic                clr,
  input  logic                shift,
  input  logic signed [W-1:0] din,
  output logic [TAPS*W-1:0]   taps_flat
);

  logic signed [W-1:0] tap_q [TAPS];

  generate
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      logic signed [W-1:0] src;
      if (k == 0) begin : g_head
        assign src = din;
      end else begin : g_link
        assign src = tap_q[k-1];
      end

      always_ff @(posedge clk) begin
        if (clr) begin
          tap_q[k] <= '0;
        end else if (shift) begin
          tap_q[k] <= src;
        end
      end

      assign taps_flat[k*W +: W] = tap_q[k];

      if (k > 0) begin : g_link_chk
        // R3
        link_shift_chk: assert property (@(posedge clk) disable iff (clr)
          shift |=> taps_flat[k*W +: W] == $past(taps_flat[(k-1)*W +: W]));
      end
    end
  endgenerate

  // R1
  taps_clear_chk: assert property (@(posedge clk) disable iff (clr)
    $fell(clr) |-> taps_flat == '0);

  // R2
  taps_hold_chk: assert property (@(posedge clk) disable iff (clr)
    !shift |=> $stable(taps_flat));

  // R3
  head_load_chk: assert property (@(posedge clk) disable iff (clr)
    shift |=> taps_flat[W-1:0] == $past(din));

endmodule

// File: rtl/fxp_fir_mac.sv
module fxp_fir_mac #(
  parameter int                    TAPS     = 9,
  parameter int                    W        = 16,
  parameter logic [TAPS*W-1:0]     COEF_VEC = '0
) (
  input  logic [TAPS*W-1:0]       taps_flat,
  output logic signed [2*W-1:0]   acc
);

  localparam int PW = 2 * W;

  logic signed [PW-1:0] part [TAPS];

  generate
    for (genvar k = 0; k < TAPS; k++) begin : g_term
      localparam logic signed [W-1:0] CK = COEF_VEC[k*W +: W];
      logic signed [W-1:0]  tap_k;
      logic signed [PW-1:0] prod_k;

      assign tap_k  = taps_flat[k*W +: W];
      assign prod_k = PW'(tap_k) * PW'(CK);

      if (k == 0) begin : g_first
        assign part[k] = prod_k;
      end else begin : g_rest
        assign part[k] = prod_k + part[k-1];
      end
    end
  endgenerate

  assign acc = part[TAPS-1];

endmodule

// File: rtl/fxp_fir.sv
module fxp_fir
  import fxp_fir_pkg::*;
#(
  parameter int          ORDER       = 8,
  parameter int          IO_W        = 16,
  parameter int          IO_FRAC     = IO_W - 1,
  parameter int          CF_W        = 16,
  parameter int          CF_FRAC     = CF_W - 1,
  parameter port_style_e PORT_STYLE  = PORT_PLAIN,
  parameter bit          RST_ACT_LOW = 1'b0,
  parameter logic [(ORDER+1)*CF_W-1:0] COEF_VEC = {
    -16'sd100, 16'sd400, 16'sd2500, 16'sd6600, 16'sd8600,
     16'sd6600, 16'sd2500, 16'sd400, -16'sd100}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   smp_en,
  input  logic signed [IO_W-1:0] smp_in,
  input  logic                   s_axis_tvalid,
  output logic                   s_axis_tready,
  output logic signed [IO_W-1:0] smp_out,
  output logic                   m_axis_tvalid,
  input  logic                   m_axis_tready
);

  localparam int TAPS = ORDER + 1;
  localparam int PW   = 2 * CF_W;
  localparam int PAD  = CF_FRAC - IO_FRAC;

  generate
    if (int_bits(IO_W, IO_FRAC) > int_bits(CF_W, CF_FRAC) || IO_FRAC > CF_FRAC) begin : g_bad_fmt
      $error("fxp_fir: I/O format wider than the coefficient format");
    end
  endgenerate

  // named internal events
  logic                   clr;
  logic                   shift_req;
  logic signed [CF_W-1:0] aligned;
  logic [TAPS*CF_W-1:0]   taps_flat;
  logic signed [PW-1:0]   acc;
  logic                   unused_ready;

  assign clr          = reset_hit(rst, RST_ACT_LOW);
  assign shift_req    = (PORT_STYLE == PORT_STREAM) ? s_axis_tvalid : smp_en;
  assign unused_ready = m_axis_tready;

  fxp_fir_align #(
    .IO_W(IO_W), .IO_FRAC(IO_FRAC), .CF_W(CF_W), .CF_FRAC(CF_FRAC)
  ) u_align (
    .raw     (smp_in),
    .aligned (aligned)
  );

  fxp_fir_taps #(
    .TAPS(TAPS), .W(CF_W)
  ) u_taps (
    .clk       (clk),
    .clr       (clr),
    .shift     (shift_req),
    .din       (aligned),
    .taps_flat (taps_flat)
  );

  fxp_fir_mac #(
    .TAPS(TAPS), .W(CF_W), .COEF_VEC(COEF_VEC)
  ) u_mac (
    .taps_flat (taps_flat),
    .acc       (acc)
  );

  // two truncating arithmetic shifts back to the I/O format
  function automatic logic signed [IO_W-1:0] rescale(input logic signed [PW-1:0] s);
    logic signed [PW-1:0]   t1;
    logic signed [CF_W-1:0] t2;
    t1 = s >>> CF_FRAC;
    t2 = t1[CF_W-1:0];
    t2 = t2 >>> PAD;
    return t2[IO_W-1:0];
  endfunction

  assign smp_out = rescale(acc);

  generate
    if (PORT_STYLE == PORT_STREAM) begin : g_stream
      logic vld_q;

      always_ff @(posedge clk) begin
        if (clr) vld_q <= 1'b0;
        else     vld_q <= s_axis_tvalid;
      end

      assign m_axis_tvalid = vld_q;
      assign s_axis_tready = 1'b1;

      // R7
      vld_clear_chk: assert property (@(posedge clk) disable iff (clr)
        $fell(clr) |-> !m_axis_tvalid);

      // R7
      vld_delay_chk: assert property (@(posedge clk) disable iff (clr)
        !$fell(clr) |-> m_axis_tvalid == $past(s_axis_tvalid));
    end else begin : g_plain
      assign m_axis_tvalid = 1'b0;
      assign s_axis_tready = 1'b0;
    end
  endgenerate

endmodule

// File: tb/fxp_fir_test.sv
module fxp_fir_test;
  import fxp_fir_pkg::*;

  localparam int CLK_T = 10;

  // uut: plain style, active-high reset, default formats, asymmetric taps
  localparam logic [9*16-1:0] CV1 = {
    -16'sd90, 16'sd300, 16'sd2000, 16'sd6000, 16'sd8600,
     16'sd6550, 16'sd2520, 16'sd410, -16'sd120};
  // uut2: stream style, active-low reset, Q2.10 I/O into Q4.16 taps
  localparam logic [5*20-1:0] CV2 = {
    20'sd5000, -20'sd12000, 20'sd30000, -20'sd12000, 20'sd5000};

  int cf1[$] = '{-120, 410, 2520, 6550, 8600, 6000, 2000, 300, -90};
  int cf2[$] = '{5000, -12000, 30000, -12000, 5000};

  logic clk = 1'b0;
  logic rst1 = 1'b1;
  logic rst2n = 1'b0;
  logic ce1 = 1'b0, ce2 = 1'b0, v1 = 1'b0, v2 = 1'b0;
  logic rdy1 = 1'b0, rdy2 = 1'b0;
  logic signed [15:0] x1 = '0;
  logic signed [11:0] x2 = '0;
  logic signed [15:0] out1;
  logic signed [11:0] out2;
  logic mv1, mv2, rdy_s1, rdy_s2;

  int  n_chk = 0, n_bad = 0;
  bit  run_cmp = 1'b0;
  bit  done = 1'b0;
  string tag = "R1";

  always #(CLK_T/2) clk = ~clk;

  fxp_fir #(
    .ORDER(8), .IO_W(16), .IO_FRAC(15), .CF_W(16), .CF_FRAC(15),
    .PORT_STYLE(PORT_PLAIN), .RST_ACT_LOW(1'b0), .COEF_VEC(CV1)
  ) uut (
    .clk(clk), .rst(rst1), .smp_en(ce1), .smp_in(x1),
    .s_axis_tvalid(v1), .s_axis_tready(rdy_s1),
    .smp_out(out1), .m_axis_tvalid(mv1), .m_axis_tready(rdy1)
  );

  fxp_fir #(
    .ORDER(4), .IO_W(12), .IO_FRAC(10), .CF_W(20), .CF_FRAC(16),
    .PORT_STYLE(PORT_STREAM), .RST_ACT_LOW(1'b1), .COEF_VEC(CV2)
  ) uut2 (
    .clk(clk), .rst(rst2n), .smp_en(ce2), .smp_in(x2),
    .s_axis_tvalid(v2), .s_axis_tready(rdy_s2),
    .smp_out(out2), .m_axis_tvalid(mv2), .m_axis_tready(rdy2)
  );

  // ---------------- behavioural reference ----------------
  longint q1[$] = '{0, 0, 0, 0, 0, 0, 0, 0, 0};
  longint q2[$] = '{0, 0, 0, 0, 0};
  bit     vq2 = 1'b0;

  function automatic longint wrapw(input longint v, input int w);
    longint m;
    m = v & ((longint'(1) << w) - 1);
    if (m >= (longint'(1) << (w - 1))) m -= (longint'(1) << w);
    return m;
  endfunction

  function automatic longint model_out(input longint q[$], input int cf[$],
                                       input int cfw, input int cff,
                                       input int iow, input int iof);
    longint sum = 0;
    longint s1;
    for (int k = 0; k < q.size(); k++) sum += q[k] * longint'(cf[k]);
    sum = wrapw(sum, 2 * cfw);
    s1  = wrapw(sum >>> cff, cfw);
    return wrapw(s1 >>> (cff - iof), iow);
  endfunction

  always @(posedge clk) begin
    if (rst1) begin
      foreach (q1[k]) q1[k] = 0;
    end else if (ce1) begin
      q1.push_front(longint'(x1));
      void'(q1.pop_back());
    end
    if (!rst2n) begin
      foreach (q2[k]) q2[k] = 0;
      vq2 = 1'b0;
    end else begin
      if (v2) begin
        q2.push_front(longint'(x2) * 64);
        void'(q2.pop_back());
      end
      vq2 = v2;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string rq, input string what, input longint got, input longint exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run_cmp && !done) begin
      chk(tag, "plain output vs model", longint'(out1), model_out(q1, cf1, 16, 15, 16, 15));
      chk(tag, "stream output vs model", longint'(out2), model_out(q2, cf2, 20, 16, 12, 10));
      chk("R7", "m_axis_tvalid delayed valid", longint'(mv2), longint'(vq2));
      chk("R8", "stream s_axis_tready", longint'(rdy_s2), 1);
      chk("R9", "plain tvalid/tready", longint'({mv1, rdy_s1}), 0);
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_T * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    longint held;
    lf = 16'hACE1;

    // reset with shift requests and data active in the same cycles
    @(negedge clk);
    tag = "R1";
    ce1 = 1'b1; v2 = 1'b1; x1 = 16'sd1234; x2 = 12'sd300;
    repeat (3) tick();
    chk("R1", "plain output under reset", longint'(out1), 0);
    chk("R1", "stream output under reset", longint'(out2), 0);
    chk("R7", "tvalid under reset", longint'(mv2), 0);
    chk("R10", "active-low reset holds uut2 at zero", longint'(out2), 0);
    run_cmp = 1'b1;

    // impulse: -1.0 into uut, -2.0 into uut2
    rst1 = 1'b0; rst2n = 1'b1;
    tag = "R3";
    x1 = -16'sd32768; x2 = -12'sd2048; ce1 = 1'b1; v2 = 1'b1;
    tick();
    chk("R5", "impulse tap 0", longint'(out1), -cf1[0]);
    chk("R4", "widened impulse first output", longint'(out2), -157);
    x1 = '0; x2 = '0;
    for (int k = 1; k < 9; k++) begin
      tick();
      chk("R5", $sformatf("impulse tap %0d", k), longint'(out1), -cf1[k]);
    end
    tick();
    chk("R5", "impulse flushed", longint'(out1), 0);

    // load, then hold with enable low while data moves
    x1 = 16'sd5000; x2 = 12'sd700;
    repeat (3) tick();
    tag = "R2";
    ce1 = 1'b0; v2 = 1'b0; ce2 = 1'b1; v1 = 1'b1;
    held = longint'(out1);
    for (int k = 0; k < 6; k++) begin
      x1 = 16'(k * 7919 - 20000); x2 = 12'(k * 311 - 900);
      tick();
      chk("R2", "output held with enable low", longint'(out1), held);
    end
    ce2 = 1'b0; v1 = 1'b0;

    // step response
    tag = "R6";
    x1 = 16'sd16384; x2 = 12'sd1024; ce1 = 1'b1; v2 = 1'b1;
    repeat (14) tick();
    chk("R6", "step settles to half of coefficient sum", longint'(out1), 13085);

    // full-scale alternation
    for (int k = 0; k < 12; k++) begin
      x1 = (k % 2 == 0) ? 16'sd32767 : -16'sd32768;
      x2 = (k % 2 == 0) ? 12'sd2047 : -12'sd2048;
      tick();
    end

    // pseudo-random data, enables and ready lines
    tag = "R8";
    for (int k = 0; k < 300; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      x1 = lf; x2 = lf[13:2];
      ce1 = lf[0]; v2 = lf[3]; ce2 = ~lf[3]; v1 = lf[5];
      rdy1 = lf[7]; rdy2 = lf[9];
      tick();
    end

    // reset one instance while the other keeps shifting
    tag = "R10";
    ce1 = 1'b1; v2 = 1'b1; x1 = 16'sd9000; x2 = 12'sd500;
    repeat (3) tick();
    rst1 = 1'b1;
    tick();
    chk("R10", "active-high reset clears uut", longint'(out1), 0);
    chk("R10", "uut2 keeps shifting while rst high", longint'(out2),
        model_out(q2, cf2, 20, 16, 12, 10));
    rst1 = 1'b0;
    repeat (3) tick();
    rst2n = 1'b0;
    tick();
    chk("R10", "active-low reset clears uut2", longint'(out2), 0);
    chk("R7", "tvalid cleared with valid high", longint'(mv2), 0);
    rst2n = 1'b1;
    repeat (4) tick();
    run_cmp = 1'b0;
    finish_run();
  end

endmodule